// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

This block lets a host read and write the control registers of an AC97 codec over the serial audio link. A host write or read request is turned into a codec command. The command goes into the command-address and command-data slots of the next outgoing frame, and the tag slot of that frame marks those two slots as valid. In the other direction, the block watches the status-address and status-data slots of incoming frames and keeps the most recent register value the codec returned.

An external frame counter supplies the slot timing. It pulses `slot_start` at each slot boundary, and `slot_num` gives the index of the slot that is starting. A frame holds 13 slots. Each slot is shown as a 20-bit word: the 16-bit tag word sits left-justified in bits 19:4, and slots 1 and 2 use the full 20 bits. Only one command can be in flight at a time, and `busy` tells the host when it may issue the next one. A read result raises a one-cycle `rd_upd` pulse only when the value differs from the one held before, so reading the same unchanged register twice gives no pulse.

Top module: `ac97_regacc`

## Requirements
- R1: The outgoing slot-0 word always has bit 19 (frame valid) set. `tx_word` is 0 after reset.
- R2: In a command frame, slot-0 bits 18 and 17 are both 1. Slot 1 carries the read flag in bit 19 (1 = read, 0 = write) and the address in bits 18:12. Slot 2 carries the write data in bits 19:4 and is 0 for a read. In every other frame, bits 18 and 17 are 0 and slots 1 and 2 are 0.
- R3: An accepted request goes out in the first frame whose slot-0 start comes strictly after the accepting clock edge. A request accepted on the same edge as a slot-0 start waits for the following frame.
- R4: `busy` is high from the cycle after acceptance. It stays high through the command frame and clears in the cycle after the next slot-0 start.
- R5: A strobe while `busy` is high is ignored, and `cmd_err` pulses high for exactly one cycle, in the cycle after the strobe. `host_wr` and `host_rd` together are rejected the same way.
- R6: A write whose `host_addr` is above 0x7F is dropped silently: `busy` stays low and no command slots are sent. A read uses only `host_addr[6:0]`.
- R7: Incoming slot-0 bit 18 qualifies slot 1, whose bits 18:12 load `rd_addr`. Incoming slot-0 bit 17 qualifies slot 2, whose bits 19:4 are the returned value. Slots that are not qualified leave `rd_addr` and `rd_data` unchanged.
- R8: `rd_data` resets to 0. A qualified value that differs from `rd_data` loads it and pulses `rd_upd` for one cycle. An equal value produces no pulse.
- R9: Outgoing slots 3 to 12 are always 0.
- R10: `tx_word` changes only in the cycle after a `slot_start` pulse and holds between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Codec register address; writes above 0x7F are dropped |
| host_wdata | input | 16 | Value for a register write |
| host_wr | input | 1 | One-cycle write request |
| host_rd | input | 1 | One-cycle read request |
| busy | output | 1 | A command is pending or being sent |
| cmd_err | output | 1 | One-cycle pulse: a request was rejected |
| rd_data | output | 16 | Last register value returned by the codec |
| rd_addr | output | 7 | Register address echoed in the last status frame |
| rd_upd | output | 1 | One-cycle pulse: `rd_data` took a new, different value |
| slot_start | input | 1 | Slot boundary strobe from the frame counter |
| slot_num | input | 4 | Index of the slot that is starting (0 to 12) |
| rx_word | input | 20 | Incoming word for the starting slot |
| tx_word | output | 20 | Outgoing word for the current slot, registered |

## Verification
The hardest case to reach from the ports is a request that arrives on the very edge that opens a frame. It must not slip into that frame. The bench raises the strobe in the same cycle as the slot-0 pulse and checks that the command appears only in the frame after it. A second hard case is the quiet repeated read. The bench feeds the same status value in two frames in a row and checks that the second frame moves neither `rd_data` nor `rd_upd`. It then feeds a value with its tag bit clear and checks that this value is not captured.

// File: rtl/ac97ra_pkg.sv
package ac97ra_pkg;
  localparam int unsigned SLOT_W    = 20;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned ADDR_LSB  = 12;
  localparam int unsigned DATA_LSB  = 4;
  localparam int unsigned TAG_FRAME = 19;
  localparam int unsigned TAG_CMD   = 18;
  localparam int unsigned TAG_DAT   = 17;
  localparam int unsigned RW_BIT    = 19;

  typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;

  typedef struct packed {
    op_e                op;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
  } cmd_t;

  // Outgoing tag word: frame valid always, slot 1/2 valid only with a command
  function automatic logic [SLOT_W-1:0] tag_slot(input logic with_cmd);
    logic [SLOT_W-1:0] w;
    w            = '0;
    w[TAG_FRAME] = 1'b1;
    w[TAG_CMD]   = with_cmd;
    w[TAG_DAT]   = with_cmd;
    return w;
  endfunction

  function automatic logic [SLOT_W-1:0] addr_slot(input cmd_t c);
    logic [SLOT_W-1:0] w;
    w                       = '0;
    w[RW_BIT]               = c.op;
    w[ADDR_LSB +: ADDR_W]   = c.addr;
    return w;
  endfunction

  function automatic logic [SLOT_W-1:0] data_slot(input cmd_t c);
    logic [SLOT_W-1:0] w;
    w = '0;
    if (c.op == OP_WR) w[DATA_LSB +: DATA_W] = c.data;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] slot_value(input logic [SLOT_W-1:0] w);
    return w[DATA_LSB +: DATA_W];
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction
endpackage

// File: rtl/ac97ra_cmd_ctrl.sv
module ac97ra_cmd_ctrl
  import ac97ra_pkg::*;
#(
  parameter int HOST_ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HOST_ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic                   frame_start,
  output logic                   pending,
  output logic                   live,
  output cmd_t                   cmd,
  output logic                   busy,
  output logic                   cmd_err
);
  logic strobe, both, bad_wr, accept, err_evt;

  assign strobe  = host_wr | host_rd;
  assign both    = host_wr & host_rd;
  assign bad_wr  = host_wr & ~host_rd & (|host_addr[HOST_ADDR_W-1:ADDR_W]);
  assign busy    = pending | live;
  assign accept  = strobe & ~busy & ~both & ~bad_wr;
  assign err_evt = strobe & (busy | both);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      live    <= 1'b0;
      cmd     <= '0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= err_evt;
      if (frame_start) begin
        live    <= pending;
        pending <= 1'b0;
      end
      if (accept) begin
        pending  <= 1'b1;
        cmd.op   <= host_rd ? OP_RD : OP_WR;
        cmd.addr <= host_addr[ADDR_W-1:0];
        cmd.data <= host_wdata;
      end
    end
  end

  AST_ERR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && busy) |=> cmd_err); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && !strobe) |=> !cmd_err); // R5
  AST_BAD_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !busy) |=> !busy); // R6
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_start) |=> busy); // R4
  AST_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (live && frame_start) |=> !live); // R4
  AST_NOT_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frame_start) |=> (pending && !live)); // R3
endmodule

// File: rtl/ac97ra_tx_fmt.sv
module ac97ra_tx_fmt
  import ac97ra_pkg::*;
#(
  parameter int SLOTS = 13,
  parameter int SIW   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic [SIW-1:0]    slot_num,
  input  logic              pending,
  input  logic              live,
  input  cmd_t              cmd,
  output logic [SLOT_W-1:0] tx_word
);
  localparam logic [SIW-1:0] S_TAG = SIW'(0);
  localparam logic [SIW-1:0] S_CMD = SIW'(1);
  localparam logic [SIW-1:0] S_DAT = SIW'(2);

  logic              cmd_now;
  logic [SLOT_W-1:0] next_word;

  // At slot 0 the frame being opened carries whatever is pending
  assign cmd_now = (slot_num == S_TAG) ? pending : live;

  always_comb begin
    next_word = '0;
    unique case (slot_num)
      S_TAG:   next_word = tag_slot(cmd_now);
      S_CMD:   if (cmd_now) next_word = addr_slot(cmd);
      S_DAT:   if (cmd_now) next_word = data_slot(cmd);
      default: next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          tx_word <= '0;
    else if (slot_start) tx_word <= next_word;
  end

  AST_FRAME_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && slot_num == S_TAG) |=> tx_word[TAG_FRAME]); // R1
  AST_IDLE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && slot_num > S_DAT) |=> (tx_word == '0)); // R9
  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable(tx_word)); // R10
  AST_TAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && slot_num == S_TAG) |=> (tx_word[TAG_CMD] == tx_word[TAG_DAT])); // R2
endmodule

// File: rtl/ac97ra_rx_cap.sv
module ac97ra_rx_cap
  import ac97ra_pkg::*;
#(
  parameter int SLOTS = 13,
  parameter int SIW   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic [SIW-1:0]    slot_num,
  input  logic [SLOT_W-1:0] rx_word,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_upd
);
  localparam logic [SIW-1:0] S_TAG = SIW'(0);
  localparam logic [SIW-1:0] S_CMD = SIW'(1);
  localparam logic [SIW-1:0] S_DAT = SIW'(2);

  logic              ok_addr, ok_data;
  logic [DATA_W-1:0] new_val;
  logic              val_differs, take_val;
  logic              unused_bits;

  assign new_val     = slot_value(rx_word);
  assign val_differs = (new_val != rd_data);
  assign take_val    = slot_start && (slot_num == S_DAT) && ok_data && val_differs;
  assign unused_bits = ^rx_word[DATA_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_addr <= 1'b0;
      ok_data <= 1'b0;
      rd_data <= '0;
      rd_addr <= '0;
      rd_upd  <= 1'b0;
    end else begin
      rd_upd <= take_val;
      if (take_val) rd_data <= new_val;
      if (slot_start && slot_num == S_TAG) begin
        ok_addr <= rx_word[TAG_CMD];
        ok_data <= rx_word[TAG_DAT];
      end
      if (slot_start && slot_num == S_CMD && ok_addr)
        rd_addr <= slot_addr(rx_word);
    end
  end

  AST_UPD_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_upd |-> (rd_data != $past(rd_data))); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_start && slot_num == S_DAT) |=> $stable(rd_data)); // R7
  AST_SAME_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && new_val == rd_data) |=> !rd_upd); // R8
endmodule

// File: rtl/ac97_regacc.sv
module ac97_regacc
  import ac97ra_pkg::*;
#(
  parameter int SLOTS       = 13,
  parameter int HOST_ADDR_W = 8,
  parameter int SIW         = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HOST_ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  input  logic                   host_wr,
  input  logic                   host_rd,
  output logic                   busy,
  output logic                   cmd_err,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic                   rd_upd,
  input  logic                   slot_start,
  input  logic [SIW-1:0]         slot_num,
  input  logic [SLOT_W-1:0]      rx_word,
  output logic [SLOT_W-1:0]      tx_word
);
  logic frame_start, pending, live;
  cmd_t cmd;

  assign frame_start = slot_start && (slot_num == SIW'(0));

  ac97ra_cmd_ctrl #(.HOST_ADDR_W(HOST_ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .frame_start(frame_start),
    .pending(pending), .live(live), .cmd(cmd), .busy(busy), .cmd_err(cmd_err)
  );

  ac97ra_tx_fmt #(.SLOTS(SLOTS), .SIW(SIW)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_num(slot_num),
    .pending(pending), .live(live), .cmd(cmd), .tx_word(tx_word)
  );

  ac97ra_rx_cap #(.SLOTS(SLOTS), .SIW(SIW)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_num(slot_num),
    .rx_word(rx_word), .rd_data(rd_data), .rd_addr(rd_addr), .rd_upd(rd_upd)
  );

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> ({1'b0, slot_num} < (SIW+1)'(SLOTS))); // R9
  AST_CMD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pending) |=> !tx_word[18]); // R2
endmodule

// File: tb/ac97_regacc_tb.sv
module ac97_regacc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic        busy, cmd_err, rd_upd;
  logic [15:0] rd_data;
  logic [6:0]  rd_addr;
  logic        slot_start = 1'b0;
  logic [3:0]  slot_num = '0;
  logic [19:0] rx_word = '0;
  logic [19:0] tx_word;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [19:0] txw [13];
  logic upd_seen, busy_after0;

  always #5 clk = ~clk;

  ac97_regacc u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .busy(busy), .cmd_err(cmd_err),
    .rd_data(rd_data), .rd_addr(rd_addr), .rd_upd(rd_upd),
    .slot_start(slot_start), .slot_num(slot_num), .rx_word(rx_word), .tx_word(tx_word)
  );

  // {is_read, host address, data}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'h02, 16'h8000},
    {1'b1, 8'h26, 16'h0000},
    {1'b0, 8'h7F, 16'hFFFF},
    {1'b0, 8'h00, 16'h0001},
    {1'b1, 8'h7F, 16'h1234},
    {1'b1, 8'hC5, 16'h0000}
  };

  function automatic logic [19:0] e_tag(input bit c);
    return c ? 20'hE0000 : 20'h80000;
  endfunction
  function automatic logic [19:0] e_s1(input bit rd, input logic [7:0] a);
    return 20'(rd) * 20'h80000 + 20'(a % 128) * 20'd4096;
  endfunction
  function automatic logic [19:0] e_s2(input bit rd, input logic [15:0] d);
    return rd ? 20'h0 : 20'(d) * 20'd16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input bit rd, input bit wr, input logic [7:0] a, input logic [15:0] d);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_rd = 0; host_wr = 0;
  endtask

  task automatic run_frame(input bit v1, input bit v2, input logic [19:0] w1,
                           input logic [19:0] w2, input bit inj, input logic [7:0] ia,
                           input logic [15:0] id);
    upd_seen = 0;
    for (int s = 0; s < 13; s++) begin
      slot_start = 1; slot_num = 4'(s);
      rx_word = (s == 0) ? {1'b1, v1, v2, 17'h0} : (s == 1) ? w1 : (s == 2) ? w2 : 20'h0;
      if (s == 0 && inj) begin host_wr = 1; host_addr = ia; host_wdata = id; end
      @(posedge clk); @(negedge clk);
      slot_start = 0; host_wr = 0;
      txw[s] = tx_word;
      if (rd_upd) upd_seen = 1;
      if (s == 0) busy_after0 = busy;
      @(negedge clk);
      if (rd_upd) upd_seen = 1;
      check(tx_word == txw[s], "R10", "tx_word held between slots", tx_word, txw[s]);
    end
  endtask

  task automatic idle_frame();
    run_frame(0, 0, 20'h0, 20'h0, 0, 8'h0, 16'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_word == 0, "R1", "tx reset", tx_word, 0);
    check(busy == 0, "R4", "busy reset", busy, 0);
    check(cmd_err == 0, "R5", "err reset", cmd_err, 0);
    check(rd_data == 0, "R8", "rd_data reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    idle_frame();
    check(txw[0] == e_tag(0), "R1", "idle tag", txw[0], e_tag(0));

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [24:0] v;
      v = VEC[i];
      strobe(v[24], !v[24], v[23:16], v[15:0]);
      check(busy == 1, "R4", "busy after accept", busy, 1);
      idle_frame();
      check(txw[0] == e_tag(1), "R2", "cmd tag", txw[0], e_tag(1));
      check(txw[1] == e_s1(v[24], v[23:16]), "R2", "slot1 (R6 mask)", txw[1], e_s1(v[24], v[23:16]));
      check(txw[2] == e_s2(v[24], v[15:0]), "R2", "slot2", txw[2], e_s2(v[24], v[15:0]));
      for (int s = 3; s < 13; s++)
        check(txw[s] == 0, "R9", "data slot zero", txw[s], 0);
      check(busy == 1, "R4", "busy through frame", busy, 1);
      idle_frame();
      check(busy_after0 == 0, "R4", "busy cleared", busy_after0, 0);
      check(txw[0] == e_tag(0), "R2", "tag after cmd", txw[0], e_tag(0));
      check(txw[1] == 0 && txw[2] == 0, "R2", "cmd slots empty", txw[1], 0);
    end

    // R3: strobe coincides with slot-0 start
    run_frame(0, 0, 20'h0, 20'h0, 1, 8'h11, 16'hABCD);
    check(txw[0] == e_tag(0), "R3", "not in same frame", txw[0], e_tag(0));
    check(busy == 1, "R3", "pending", busy, 1);
    idle_frame();
    check(txw[1] == e_s1(0, 8'h11), "R3", "next frame slot1", txw[1], e_s1(0, 8'h11));
    check(txw[2] == e_s2(0, 16'hABCD), "R3", "next frame slot2", txw[2], e_s2(0, 16'hABCD));
    idle_frame();

    // R5: strobe while busy
    strobe(0, 1, 8'h10, 16'h1111);
    strobe(1, 0, 8'h20, 16'h0);
    check(cmd_err == 1, "R5", "err pulse", cmd_err, 1);
    @(negedge clk);
    check(cmd_err == 0, "R5", "err one cycle", cmd_err, 0);
    idle_frame();
    check(txw[1] == e_s1(0, 8'h10), "R5", "first cmd kept", txw[1], e_s1(0, 8'h10));
    check(txw[2] == e_s2(0, 16'h1111), "R5", "first data kept", txw[2], e_s2(0, 16'h1111));
    idle_frame();
    check(busy == 0, "R5", "no second cmd", busy, 0);

    // R5: both strobes
    strobe(1, 1, 8'h05, 16'h2222);
    check(cmd_err == 1, "R5", "both strobes err", cmd_err, 1);
    check(busy == 0, "R5", "both strobes no busy", busy, 0);
    idle_frame();
    check(txw[0] == e_tag(0), "R5", "both strobes no cmd", txw[0], e_tag(0));

    // R6: bad write address
    strobe(0, 1, 8'h85, 16'h3333);
    check(busy == 0, "R6", "bad addr no busy", busy, 0);
    check(cmd_err == 0, "R6", "bad addr no err", cmd_err, 0);
    idle_frame();
    check(txw[0] == e_tag(0) && txw[1] == 0, "R6", "bad addr no slots", txw[0], e_tag(0));

    // R7/R8: capture
    run_frame(1, 1, 20'h15000, 20'h00000, 0, 8'h0, 16'h0);
    check(upd_seen == 0, "R8", "zero equals reset value", upd_seen, 0);
    run_frame(1, 1, 20'h2A000, 20'h12340, 0, 8'h0, 16'h0);
    check(rd_data == 16'h1234, "R7", "value captured", rd_data, 16'h1234);
    check(rd_addr == 7'h2A, "R7", "addr captured", rd_addr, 7'h2A);
    check(upd_seen == 1, "R8", "update on change", upd_seen, 1);
    run_frame(1, 1, 20'h2A000, 20'h12340, 0, 8'h0, 16'h0);
    check(upd_seen == 0, "R8", "no update on repeat", upd_seen, 0);
    check(rd_data == 16'h1234, "R8", "value kept", rd_data, 16'h1234);
    run_frame(1, 1, 20'h31000, 20'hBEEF0, 0, 8'h0, 16'h0);
    check(upd_seen == 1 && rd_data == 16'hBEEF, "R8", "second change", rd_data, 16'hBEEF);
    run_frame(0, 0, 20'h11000, 20'h55550, 0, 8'h0, 16'h0);
    check(upd_seen == 0, "R7", "untagged no update", upd_seen, 0);
    check(rd_data == 16'hBEEF, "R7", "untagged data ignored", rd_data, 16'hBEEF);
    check(rd_addr == 7'h31, "R7", "untagged addr ignored", rd_addr, 7'h31);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule